// File: doc/BRIEF.md
# Up/Down Trim Code Controller

This block holds the 8-bit setting of a 256-step trim. The setting is adjusted through a three-wire counter-style port, and the block keeps it across power cycles in a nonvolatile memory. The three wires are an active-low select, a strobe and a direction level. The block samples all three on its own clock through two-flop synchronisers. It then detects edges by comparing each synchronised level with a copy delayed by one cycle. While the block is selected, every high-to-low strobe transition moves the code one step. The code goes up if the direction level is high and down if it is low. At either end of the range the code stops rather than wrapping. The code output drives a resistor DAC, which lies outside this block.

Leaving the adjustment session commits the code or discards it. If select rises while the strobe is high, the block stores the present code. If the strobe is low at that moment, nothing is written and the stored code stays as it was. After reset, the block waits for the memory to present the recalled value. It loads that value and only then accepts strobe edges.

Writing to the memory is a one-way transfer with back-pressure. `nv_wr_o` is a single-cycle request that carries `nv_wdata_o`. It is never raised while `nv_busy_i` is high. A store that becomes due during busy is held and issued in the first cycle that busy is low. One deselect event gives at most one request. The recall port has no ready signal, because the block always accepts the value on the first cycle `nv_rvalid_i` is high after reset.

Top module: `trim_ctrl`

## Requirements
- R1: After reset `code_o` is 0 until the first cycle `nv_rvalid_i` is high. The next clock then loads `code_o` with `nv_rdata_i`.
- R2: Before the recalled value has loaded, strobe falls and deselect events change nothing and cause no write request.
- R3: While select is low (0), a strobe fall with the direction input at 1 raises the code by exactly one.
- R4: While select is low, a strobe fall with the direction input at 0 lowers the code by exactly one.
- R5: A rising strobe edge leaves the code unchanged. So does any strobe edge while select is high (1).
- R6: The code saturates. An up step at 255 leaves 255, and a down step at 0 leaves 0.
- R7: When select rises while the strobe is at 1, the block raises exactly one `nv_wr_o` pulse, and `nv_wdata_o` equals the code at that time.
- R8: When select rises while the strobe is at 0, no `nv_wr_o` is raised.
- R9: While `nv_busy_i` is 1, strobe falls leave the code unchanged. A store that becomes due during busy is issued once, after busy drops.
- R10: `nv_wr_o` lasts one cycle for each store and is never high while `nv_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low select of the adjustment port (asynchronous) |
| step_i | input | 1 | Step strobe; its falling edge moves the code (asynchronous) |
| dir_i | input | 1 | Direction: 1 counts up, 0 counts down (asynchronous) |
| nv_rvalid_i | input | 1 | Recalled value from the memory is valid |
| nv_rdata_i | input | 8 | Recalled code |
| nv_busy_i | input | 1 | Memory busy; blocks write requests and steps |
| nv_wr_o | output | 1 | Single-cycle write request |
| nv_wdata_o | output | 8 | Code to be written |
| code_o | output | 8 | Present trim code |

## Verification
The bench steps the code to both ends of its range and then past them. A design that wraps would jump from 255 to 0 or from 0 to 255. The bench leaves the session both with the strobe high and with it low, and counts write pulses. A design that reads the wrong strobe level stores when it should not, and a design that detects the select edge badly stores twice or never. The bench also drives strobe edges before the recall and during busy. A design without those gates would drift away from the recalled value, or write while the memory is still busy.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int CODE_W      = 8;
  localparam int SYNC_STAGES = 2;

  // synchronised control pins of the adjustment port
  typedef struct packed {
    logic sel_n;
    logic step;
    logic dir;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sel_n: 1'b1, step: 1'b1, dir: 1'b0};
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else if (g == 0) stg[g] <= d_i;
        else stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/trim_code.sv
module trim_code #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (load_i)
      code_d = load_val_i;
    else if (step_i) begin
      if (up_i && code_q != CODE_MAX)
        code_d = code_q + 1'b1;
      else if (!up_i && code_q != CODE_MIN)
        code_d = code_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/trim_store.sv
module trim_store (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic busy_i,
  output logic wr_o
);
  logic pend_q;

  assign wr_o = pend_q && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= arm_i || (pend_q && !wr_o);
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl #(
  parameter int CODE_W      = trim_pkg::CODE_W,
  parameter int SYNC_STAGES = trim_pkg::SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              step_i,
  input  logic              dir_i,
  input  logic              nv_rvalid_i,
  input  logic [CODE_W-1:0] nv_rdata_i,
  input  logic              nv_busy_i,
  output logic              nv_wr_o,
  output logic [CODE_W-1:0] nv_wdata_o,
  output logic [CODE_W-1:0] code_o
);
  import trim_pkg::*;

  localparam int PW = $bits(pins_t);

  pins_t       pins_raw, pins_s, pins_d;
  logic [PW-1:0] pins_s_vec;
  logic        recalled_q;
  logic        sel_s;
  logic        step_fall, sel_rise, step_ev, arm;
  logic [CODE_W-1:0] code;

  assign pins_raw = '{sel_n: sel_n_i, step: step_i, dir: dir_i};

  trim_sync #(
    .W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s_vec)
  );
  assign pins_s = pins_t'(pins_s_vec);
  assign sel_s  = pins_s.sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_d     <= PINS_IDLE;
      recalled_q <= 1'b0;
    end else begin
      pins_d <= pins_s;
      if (nv_rvalid_i) recalled_q <= 1'b1;
    end
  end

  assign step_fall = pins_d.step && !pins_s.step;
  assign sel_rise  = pins_s.sel_n && !pins_d.sel_n;
  assign step_ev   = step_fall && !pins_s.sel_n && recalled_q && !nv_busy_i;
  assign arm       = sel_rise && pins_s.step && recalled_q;

  trim_code #(.CODE_W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n),
    .load_i(nv_rvalid_i && !recalled_q), .load_val_i(nv_rdata_i),
    .step_i(step_ev), .up_i(pins_s.dir),
    .code_o(code)
  );

  trim_store u_store (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .busy_i(nv_busy_i), .wr_o(nv_wr_o)
  );

  assign nv_wdata_o = code;
  assign code_o     = code;
endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_s,
  input logic              recalled,
  input logic              busy,
  input logic              wr,
  input logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  AST_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !busy); // R10

  AST_NO_WR_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !recalled |-> !wr); // R2

  AST_HOLD_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(recalled) && $past(sel_s)) |-> $stable(code)); // R5

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(recalled) && $past(busy)) |-> $stable(code)); // R9

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(recalled) && $past(code) == TOP) |-> code != '0); // R6

  AST_NO_WRAP_BOT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(recalled) && $past(code) == '0) |-> code != TOP); // R6

  AST_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!recalled) && !recalled) |-> code == '0); // R1
endmodule

bind trim_ctrl trim_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .recalled(recalled_q),
  .busy(nv_busy_i), .wr(nv_wr_o), .code(code_o)
);

// File: tb/tb_trim_ctrl.sv
module tb_trim_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, step = 1'b1, dir = 1'b0;
  logic rvalid = 1'b0, busy = 1'b0;
  logic [7:0] rdata = '0;
  logic wr;
  logic [7:0] wdata, code;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [7:0] last_wdata = '0;

  always #5 clk = ~clk;

  trim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .step_i(step), .dir_i(dir),
    .nv_rvalid_i(rvalid), .nv_rdata_i(rdata), .nv_busy_i(busy),
    .nv_wr_o(wr), .nv_wdata_o(wdata), .code_o(code)
  );

  always @(posedge clk) begin
    if (rst_n && wr) begin
      wr_cnt <= wr_cnt + 1;
      last_wdata <= wdata;
      if (busy) begin
        checks++; fails++;
        $display("FAIL R10 write while busy act=1 exp=0");
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  task automatic pulse();
    @(negedge clk) step = 1'b0; settle();
    step = 1'b1; settle();
  endtask

  task automatic do_reset(logic [7:0] val, bit recall);
    @(negedge clk) rst_n = 1'b0; sel_n = 1'b1; step = 1'b1; dir = 1'b0;
    rvalid = 1'b0; busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    if (recall) begin
      rdata = val; rvalid = 1'b1;
      @(negedge clk) rvalid = 1'b0;
      settle();
    end
  endtask

  // {sel_n, step, dir, expected code}; recalled start value is 100
  localparam logic [10:0] VEC [12] = '{
    {3'b111, 8'd100}, {3'b011, 8'd100}, {3'b001, 8'd101}, {3'b011, 8'd101},
    {3'b001, 8'd102}, {3'b010, 8'd102}, {3'b000, 8'd101}, {3'b010, 8'd101},
    {3'b000, 8'd100}, {3'b100, 8'd100}, {3'b110, 8'd100}, {3'b100, 8'd100}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 / R2: no recall yet, edges and deselect ignored
    do_reset(8'd0, 1'b0);
    chk("R1 reset code", code, 0);
    @(negedge clk) sel_n = 1'b0; dir = 1'b1; settle();
    pulse(); pulse();
    chk("R2 steps before recall", code, 0);
    @(negedge clk) sel_n = 1'b1; settle();
    chk("R2 no store before recall", wr_cnt, 0);
    rdata = 8'd50; rvalid = 1'b1;
    @(negedge clk) rvalid = 1'b0; settle();
    chk("R1 recall load", code, 50);

    // table walk: R3 R4 R5 R8
    do_reset(8'd100, 1'b1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk) {sel_n, step, dir} = VEC[i][10:8];
      settle();
      chk($sformatf("R3/R4/R5 vector %0d", i), code, VEC[i][7:0]);
    end
    chk("R8 no store with strobe low", wr_cnt, 0);

    // R7: deselect with strobe high stores once
    @(negedge clk) sel_n = 1'b0; step = 1'b1; settle();
    @(negedge clk) sel_n = 1'b1; settle();
    chk("R7 one store", wr_cnt, 1);
    chk("R7 store data", last_wdata, 100);

    // R6 top saturation
    do_reset(8'd254, 1'b1);
    @(negedge clk) sel_n = 1'b0; dir = 1'b1; settle();
    pulse(); pulse(); pulse();
    chk("R6 saturate 255", code, 255);
    @(negedge clk) dir = 1'b0; settle();
    pulse();
    chk("R6 step down from 255", code, 254);

    // R6 bottom saturation
    do_reset(8'd1, 1'b1);
    @(negedge clk) sel_n = 1'b0; dir = 1'b0; settle();
    pulse(); pulse(); pulse();
    chk("R6 saturate 0", code, 0);

    // R9: busy blocks steps and defers store
    do_reset(8'd30, 1'b1);
    wr_cnt = 0;
    @(negedge clk) sel_n = 1'b0; dir = 1'b1; busy = 1'b1; settle();
    pulse();
    chk("R9 step ignored while busy", code, 30);
    @(negedge clk) sel_n = 1'b1; settle(); settle();
    chk("R9 store held while busy", wr_cnt, 0);
    @(negedge clk) busy = 1'b0; settle();
    chk("R9 deferred store once", wr_cnt, 1);
    chk("R9 deferred data", last_wdata, 30);
    @(negedge clk) sel_n = 1'b0; settle();
    pulse();
    chk("R3 step after busy", code, 31);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule